// File: doc/BRIEF.md
# Digital Gain Stage with 16-Bit Word Extraction

This block sits after a decimation filter that delivers 24-bit signed samples. It applies a digital gain between 1 and 4 (0 dB to 12 dB) and returns a 16-bit signed sample cut from the scaled word. At the largest gain, the output is the 16 bits that follow the two top bits of the input word. At unity gain, the output is the 16 top bits of the input word. The gain comes from a gain index. Indices on whole octaves (gains 1, 2 and 4) are pure shifts. The indices between them multiply by a 6-bit mantissa. The result is rounded to nearest and clipped symmetrically to 16 bits.

A small loop sets the gain index. On every accepted sample, the loop takes the larger of two level estimates: one from an earlier filter stage and one taken after this gain. It compares that level with an upper and a lower threshold. Large signals step the gain down. Small signals step it back up. Levels between the two thresholds leave the gain where it is, which keeps the loop from chattering. Once the gain has reached 1 and the level is still too high, the block raises a flag. The flag asks the analog path upstream to widen its full scale, because the block cannot reduce the level further itself.

Top module: `dvga_extract`

## Requirements
- R1: While reset is applied and when it is released, out_valid, out_data and atten_req are 0 and the gain index is at its maximum, 8, which is gain 4.
- R2: out_valid equals in_valid delayed by exactly two clock cycles. out_data changes only on the cycle that out_valid is 1, and holds its value otherwise.
- R3: At gain index 0 (gain 1), out_data is the input value x divided by 256 and rounded to nearest, with halves rounded toward plus infinity. This is the 16 top bits of the word, rounded.
- R4: At gain index 8 (gain 4), out_data is x divided by 64 and rounded the same way, then clipped. This is the 16 bits below the two top bits of the word.
- R5: For any gain index k from 0 to 8, let m = 32 + 8*(k mod 4) and s = k div 4. Then out_data = clip(floor((x*m*2^s + 4096) / 8192)). A sample uses the gain index held when that sample is accepted.
- R6: Results above 32767 give 32767, and results below -32767 give -32767. The value -32768 never appears on out_data.
- R7: The level used by the loop is the larger of est_early and est_post, both read as unsigned numbers.
- R8: On an accepted sample whose level is above HI_TH (default 20000), the gain index drops by one, unless it is already 0.
- R9: On an accepted sample whose level is below LO_TH (default 10000), the gain index rises by one, unless it is already 8.
- R10: On an accepted sample whose level is between LO_TH and HI_TH, both limits included, the gain index holds.
- R11: On each accepted sample, atten_req is loaded with 1 if the gain index was 0 and the level was above HI_TH, and with 0 otherwise. It holds its value between accepted samples.
- R12: When in_valid is 0, the estimate inputs have no effect. The gain index and atten_req keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed sample from the decimation filter |
| est_early | input | 16 | Unsigned level estimate from the earlier filter stage |
| est_post | input | 16 | Unsigned level estimate taken after the gain |
| out_valid | output | 1 | Output sample strobe, two cycles after in_valid |
| out_data | output | 16 | Signed scaled, rounded and clipped sample |
| atten_req | output | 1 | Request for more attenuation from the upstream analog path |

## Verification
Four kinds of input pattern are used.
- Small samples at exactly half an output step, one positive and one negative, separate round-half-up from truncation and from round-half-away-from-zero.
- Full-scale samples of both signs, at gain 4 and at gain 1, separate symmetric clipping from plain two's-complement saturation.
- Estimates that walk the gain through every index, with the high estimate placed first on one input and then on the other, show whether each mantissa/shift pair is right and whether the maximum is taken.
- Estimates that sit exactly on either threshold, and strong estimates applied while in_valid is low, separate hold from a step and show that idle cycles cannot move the gain.

// File: rtl/dvga_pkg.sv
package dvga_pkg;

  // Region of the loop level relative to the two thresholds
  typedef enum logic [1:0] {
    ZONE_QUIET = 2'd0,
    ZONE_BAND  = 2'd1,
    ZONE_LOUD  = 2'd2
  } lvl_zone_e;

  // Mantissa of a gain index: unity plus a linear fraction of the octave
  function automatic int unsigned mant_of(input int unsigned idx,
                                          input int unsigned steps,
                                          input int unsigned mw);
    int unsigned unity;
    unity = 1 << (mw - 1);
    return unity + (unity * (idx % steps)) / steps;
  endfunction

  // Whole-octave shift of a gain index
  function automatic int unsigned shift_of(input int unsigned idx,
                                           input int unsigned steps);
    return idx / steps;
  endfunction

endpackage

// File: rtl/dvga_gain_ctrl.sv
module dvga_gain_ctrl #(
  parameter int EST_W   = 16,
  parameter int STEPS   = 4,
  parameter int OCTAVES = 2,
  parameter int HI_TH   = 20000,
  parameter int LO_TH   = 10000,
  localparam int KMAX   = STEPS * OCTAVES,
  localparam int IDX_W  = $clog2(KMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [EST_W-1:0] est_a,
  input  logic [EST_W-1:0] est_b,
  output logic [IDX_W-1:0] gain_idx,
  output logic             atten_req
);
  import dvga_pkg::*;

  localparam logic [EST_W-1:0] HI_LVL  = EST_W'(HI_TH);
  localparam logic [EST_W-1:0] LO_LVL  = EST_W'(LO_TH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(KMAX);

  logic [EST_W-1:0] level;
  lvl_zone_e        zone;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             att_q, att_d;

  // Larger of the two estimates drives the loop
  always_comb begin
    level = (est_a > est_b) ? est_a : est_b;
  end

  always_comb begin
    if (level > HI_LVL)
      zone = ZONE_LOUD;
    else if (level < LO_LVL)
      zone = ZONE_QUIET;
    else
      zone = ZONE_BAND;
  end

  // Next state: one step per accepted sample, hold inside the band
  always_comb begin
    idx_d = idx_q;
    att_d = att_q;
    if (upd) begin
      att_d = (zone == ZONE_LOUD) && (idx_q == '0);
      unique case (zone)
        ZONE_LOUD:  if (idx_q != '0)     idx_d = idx_q - 1'b1;
        ZONE_QUIET: if (idx_q != IDX_TOP) idx_d = idx_q + 1'b1;
        default:    idx_d = idx_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_TOP;
      att_q <= 1'b0;
    end else if (upd) begin
      idx_q <= idx_d;
      att_q <= att_d;
    end
  end

  assign gain_idx  = idx_q;
  assign atten_req = att_q;

endmodule

// File: rtl/dvga_scale_mult.sv
module dvga_scale_mult #(
  parameter int IN_W    = 24,
  parameter int MANT_W  = 6,
  parameter int STEPS   = 4,
  parameter int OCTAVES = 2,
  localparam int KMAX   = STEPS * OCTAVES,
  localparam int IDX_W  = $clog2(KMAX + 1),
  localparam int SH_W   = $clog2(OCTAVES + 1),
  localparam int PROD_W = IN_W + MANT_W + 1,
  localparam int TAB_N  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic [IDX_W-1:0]  gain_idx,
  output logic              s1_valid,
  output logic [PROD_W-1:0] s1_prod,
  output logic [SH_W-1:0]   s1_shift
);
  import dvga_pkg::*;

  logic [MANT_W-1:0] mant_tab  [TAB_N];
  logic [SH_W-1:0]   shift_tab [TAB_N];

  // Gain table built per index; unused codes clamp to the top entry
  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    localparam int unsigned EIDX = (i > KMAX) ? KMAX : i;
    assign mant_tab[i]  = MANT_W'(mant_of(EIDX, STEPS, MANT_W));
    assign shift_tab[i] = SH_W'(shift_of(EIDX, STEPS));
  end

  logic signed [PROD_W-1:0] prod_d;
  logic [MANT_W-1:0]        mant_sel;
  logic [SH_W-1:0]          shift_d;

  always_comb begin
    mant_sel = mant_tab[gain_idx];
    shift_d  = shift_tab[gain_idx];
    prod_d   = $signed(in_data) * $signed({1'b0, mant_sel});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      s1_valid <= 1'b0;
    else
      s1_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_prod  <= '0;
      s1_shift <= '0;
    end else if (in_valid) begin
      s1_prod  <= prod_d;
      s1_shift <= shift_d;
    end
  end

endmodule

// File: rtl/dvga_round_sat.sv
module dvga_round_sat #(
  parameter int PROD_W  = 31,
  parameter int SH_W    = 2,
  parameter int MAX_SH  = 2,
  parameter int FRAC    = 13,
  parameter int OUT_W   = 16,
  localparam int EXT_W  = PROD_W + MAX_SH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [PROD_W-1:0] s1_prod,
  input  logic [SH_W-1:0]   s1_shift,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  localparam logic signed [EXT_W-1:0] HALF   = EXT_W'(1) <<< (FRAC - 1);
  localparam logic signed [EXT_W-1:0] SAT_HI = (EXT_W'(1) <<< (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] SAT_LO = -SAT_HI;

  logic signed [EXT_W-1:0] ext, scaled, biased, quot;
  logic [OUT_W-1:0]        res_d;

  always_comb begin
    ext    = EXT_W'($signed(s1_prod));
    scaled = ext <<< s1_shift;
    biased = scaled + HALF;
    quot   = biased >>> FRAC;
    if (quot > SAT_HI)
      res_d = SAT_HI[OUT_W-1:0];
    else if (quot < SAT_LO)
      res_d = SAT_LO[OUT_W-1:0];
    else
      res_d = quot[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_data <= '0;
    else if (s1_valid)
      out_data <= res_d;
  end

endmodule

// File: rtl/dvga_extract.sv
module dvga_extract #(
  parameter int IN_W    = 24,
  parameter int OUT_W   = 16,
  parameter int EST_W   = 16,
  parameter int MANT_W  = 6,
  parameter int STEPS   = 4,
  parameter int OCTAVES = 2,
  parameter int HI_TH   = 20000,
  parameter int LO_TH   = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [EST_W-1:0] est_early,
  input  logic [EST_W-1:0] est_post,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             atten_req
);
  localparam int KMAX   = STEPS * OCTAVES;
  localparam int IDX_W  = $clog2(KMAX + 1);
  localparam int SH_W   = $clog2(OCTAVES + 1);
  localparam int PROD_W = IN_W + MANT_W + 1;
  localparam int FRAC   = (MANT_W - 1) + (IN_W - OUT_W);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [IDX_W-1:0]  gain_idx;
  logic              s1_valid;
  logic [PROD_W-1:0] s1_prod;
  logic [SH_W-1:0]   s1_shift;

  dvga_gain_ctrl #(
    .EST_W(EST_W), .STEPS(STEPS), .OCTAVES(OCTAVES),
    .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .upd(in_valid),
    .est_a(est_early), .est_b(est_post),
    .gain_idx(gain_idx), .atten_req(atten_req)
  );

  dvga_scale_mult #(
    .IN_W(IN_W), .MANT_W(MANT_W), .STEPS(STEPS), .OCTAVES(OCTAVES)
  ) u_mult (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_data(in_data),
    .gain_idx(gain_idx), .s1_valid(s1_valid), .s1_prod(s1_prod),
    .s1_shift(s1_shift)
  );

  dvga_round_sat #(
    .PROD_W(PROD_W), .SH_W(SH_W), .MAX_SH(OCTAVES), .FRAC(FRAC), .OUT_W(OUT_W)
  ) u_rnd (
    .clk(clk), .rst_n(rst_sync_n), .s1_valid(s1_valid), .s1_prod(s1_prod),
    .s1_shift(s1_shift), .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/dvga_extract_chk.sv
module dvga_extract_chk #(
  parameter int OUT_W = 16,
  parameter int IDX_W = 4,
  parameter int KMAX  = 8
) (
  input logic             clk,
  input logic             arst_n,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             atten_req,
  input logic [IDX_W-1:0] gain_idx
);
  // Cycles seen since the internal reset was released, saturating at 2
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      warm <= 2'd0;
    else if (warm != 2'd2)
      warm <= warm + 2'd1;
  end

  // R1: state on release of the internal reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> (gain_idx == IDX_W'(KMAX)) && !out_valid && !atten_req
                     && (out_data == '0));

  // R2: two-cycle valid latency
  a_r2_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R2: data holds on cycles without a result
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) && !out_valid |-> $stable(out_data));

  // R6: symmetric clip never yields the most negative code
  a_r6_no_minneg: assert property (@(posedge clk) disable iff (!rst_n)
    out_data != {1'b1, {(OUT_W-1){1'b0}}});

  // R8 R9: gain index moves by at most one step and stays in range
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) |-> (gain_idx <= IDX_W'(KMAX)) &&
      ((gain_idx == $past(gain_idx)) || (gain_idx == $past(gain_idx) + 1'b1) ||
       (gain_idx == $past(gain_idx) - 1'b1)));

  // R11: a request only stands at unity gain
  a_r11_att_unity: assert property (@(posedge clk) disable iff (!rst_n)
    atten_req |-> (gain_idx == '0));

  // R12: idle cycles leave the loop untouched
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) && !$past(in_valid) |-> $stable(gain_idx) && $stable(atten_req));

endmodule

bind dvga_extract dvga_extract_chk #(
  .OUT_W(OUT_W), .IDX_W(IDX_W), .KMAX(KMAX)
) u_chk (
  .clk(clk), .arst_n(rst_n), .rst_n(rst_sync_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .atten_req(atten_req),
  .gain_idx(gain_idx)
);

// File: tb/tb_dvga_extract.sv
module tb_dvga_extract;
  localparam int HI = 20000;
  localparam int LO = 10000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_data;
  logic [15:0] est_early, est_post;
  logic        out_valid;
  logic [15:0] out_data;
  logic        atten_req;

  dvga_extract dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .est_early(est_early), .est_post(est_post), .out_valid(out_valid),
    .out_data(out_data), .atten_req(atten_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Reference model state
  int m_k;
  bit m_att;
  bit d1v, d2v;
  int d1d, d2d;

  function automatic int ref_out(input int x, input int k);
    longint p;
    int m, s;
    m = 32 + 8 * (k % 4);
    s = k / 4;
    p = longint'(x) * m * (longint'(1) << s);
    p = (p + 4096) >>> 13;
    if (p > 32767)  p = 32767;
    if (p < -32767) p = -32767;
    return int'(p);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 8; m_att = 0; d1v = 0; d2v = 0; d1d = 0; d2d = 0;
    end else begin
      int lvl;
      if (d1v) d2d = d1d;
      d2v = d1v;
      if (in_valid) begin
        d1d = ref_out(int'($signed(in_data)), m_k);
        lvl = (est_early > est_post) ? int'(est_early) : int'(est_post);
        m_att = (m_k == 0) && (lvl > HI);
        if (lvl > HI) begin
          if (m_k > 0) m_k--;
        end else if (lvl < LO) begin
          if (m_k < 8) m_k++;
        end
      end
      d1v = in_valid;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== d2v || $signed(out_data) !== 16'(d2d) || atten_req !== m_att) begin
        errors++;
        $display("FAIL %s t=%0t actual v=%0b d=%0d att=%0b expected v=%0b d=%0d att=%0b",
                 cur_req, $time, out_valid, $signed(out_data), atten_req,
                 d2v, d2d, m_att);
      end
    end
  end

  task automatic drive(input bit v, input int x, input int ea, input int eb);
    @(negedge clk);
    in_valid  = v;
    in_data   = x[23:0];
    est_early = ea[15:0];
    est_post  = eb[15:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0; est_early = '0; est_post = '0;
    // R1: reset values while held
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_data !== 0 || atten_req !== 0) begin
      errors++;
      $display("FAIL R1 actual v=%0b d=%0d att=%0b expected 0 0 0",
               out_valid, out_data, atten_req);
    end
    rst_n = 1;
    idle(4);

    // R4 R2: gain 4, rounding of halves, mid-band estimates keep the gain
    cur_req = "R4";
    drive(1, 1000, 15000, 15000);
    drive(1, -1000, 15000, 15000);
    drive(1, 32, 15000, 15000);
    drive(1, -32, 15000, 15000);
    cur_req = "R6";
    drive(1, 1 << 21, 15000, 15000);
    drive(1, -(1 << 21), 15000, 15000);
    drive(1, -(1 << 23), 15000, 15000);
    cur_req = "R2";
    for (int i = 0; i < 6; i++) drive(i % 2, 4096 * i - 7000, 12000, 12000);
    idle(3);

    // R10: levels exactly on the thresholds hold the gain
    cur_req = "R10";
    drive(1, 5000, HI, 0);
    drive(1, 5000, 0, LO);
    drive(1, 5000, HI, LO);

    // R8 R5: walk down with the loud estimate on the early input
    cur_req = "R8";
    for (int i = 0; i < 4; i++) drive(1, 300001 - 77 * i, 30000, 100);
    // R7: loud estimate moved to the other input
    cur_req = "R7";
    for (int i = 0; i < 4; i++) drive(1, -299999 + 55 * i, 100, 30000);
    cur_req = "R5";
    drive(1, 123456, 15000, 15000);

    // R11: at unity gain the request rises, R3 values at gain 1
    cur_req = "R11";
    drive(1, 383, 40000, 0);
    drive(1, 384, 40000, 0);
    cur_req = "R3";
    drive(1, -384, 15000, 15000);
    drive(1, -385, 15000, 15000);
    cur_req = "R6";
    drive(1, (1 << 23) - 1, 15000, 15000);
    drive(1, -(1 << 23), 15000, 15000);

    // R12: strong and weak estimates on idle cycles change nothing
    cur_req = "R12";
    drive(1, 1000, 40000, 0);
    for (int i = 0; i < 5; i++) drive(0, 999, 60000, 0);
    for (int i = 0; i < 5; i++) drive(0, 999, 0, 0);
    drive(1, 2000, 15000, 15000);
    idle(3);

    // R9: quiet signal raises the gain back to the top, and R11 clears
    cur_req = "R9";
    for (int i = 0; i < 11; i++) drive(1, 20000 + 1000 * i, 200, 300);

    // R5: mixed patterns across gain changes
    cur_req = "R5";
    begin
      int seed;
      seed = 12345;
      for (int i = 0; i < 120; i++) begin
        int x, e;
        seed = seed * 1103515245 + 12345;
        x = (seed >>> 8) % (1 << 23);
        e = ((seed >>> 4) & 32'h7fff) * 2;
        drive((i % 5) != 0, x, e, 65535 - e);
      end
    end
    idle(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule